// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Engine

This block is the converter side of a four-wire SPI-compatible port for a slow delta-sigma converter. The host supplies the serial clock. The port runs in single-cycle mode: a conversion runs, the converter then goes to sleep holding its result, and the host reads it back. While chip select is low and no transfer is running, the serial output works as a busy flag. It reads high while a conversion is in progress and low once the result is waiting. The first rising serial clock edge in the sleep state starts a 32-bit readout. The falling edge that ends bit 32 starts the next conversion. One select/clock sequence therefore both collects a result and triggers the next one.

Chip select, serial clock and serial data in are brought into the system clock with two-flop synchronizers, and their edges are found there. The serial clock must run at no more than a quarter of the system clock rate. A small timer stands in for the modulator. It counts a programmable number of system clocks, after which the port captures the 31-bit result word from its input. The first eight serial input bits of a complete transfer become the configuration output. A transfer that chip select ends early leaves the configuration and the stored result untouched.

Top module: `adc_serial_port`

## Requirements
- R1: The port samples the synchronized serial clock level at each falling edge of chip select. Only a low level enables the port for that select-low period. When the level is high, `sdo_oe` stays 0 and serial clock edges have no effect until chip select goes high again.
- R2: `sdo_oe` is 0 from the 4th system clock after chip select goes high, for as long as chip select stays high.
- R3: While the port is enabled and no transfer is running, `sdo` is 1 during a conversion and 0 in the sleep state.
- R4: When a conversion ends, the port enters the sleep state and captures `result_i`, whatever the level of chip select.
- R5: The first rising serial clock edge with chip select low in the sleep state starts a transfer. Serial clock edges during a conversion are ignored.
- R6: The frame is the 32-bit word {1'b0, result_i[30:0]}, sent MSB first. It is stable for sampling at rising edge k (1 to 32), which sees frame bit 32-k. Bit 31 is the end-of-conversion flag, which is 0. `sdo` changes only after falling serial clock edges.
- R7: The 32nd falling serial clock edge starts a new conversion, and `sdo` then reads 1.
- R8: A conversion lasts `conv_cycles` system clocks, with 0 treated as 1. No more than 12 system clocks pass from the 32nd falling edge to the sleep state beyond that count. A new conversion never starts while the timer is busy.
- R9: Chip select going high during a transfer aborts it. The port returns to sleep with the result kept, and the next transfer sends the whole frame again.
- R10: `cfg_o` takes the SDI bits sampled on rising edges 1 to 8, first bit in the MSB. It is updated only when a full 32-bit transfer completes.
- R11: In reset, `sdo_oe` and `cfg_o` are 0. A conversion starts after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sck | input | 1 | Host serial clock, asynchronous |
| sdi | input | 1 | Host serial data in, asynchronous |
| conv_cycles | input | CNT_W | Conversion length in system clocks, 0 treated as 1 |
| result_i | input | FRAME_W-1 | Result word from the conversion model |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the tri-stated serial data pin |
| cfg_o | output | CFG_W | Configuration word from the last full transfer |

## Verification
The checks assume that the host keeps each serial clock level for at least two system clocks. They also assume that SDI changes together with a falling serial clock edge, so that it passes through the synchronizer alongside the clock. Chip select is assumed to change only while the serial clock is steady. The bench drives every input on a falling system clock edge and holds each serial clock phase for four system clocks. It waits several system clocks between chip select changes and clock edges. It samples `sdo` just before it drives each rising edge, which is the point where the host would sample.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_XFER  = 2'd2
  } port_state_e;
endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d  = (cycles == '0) ? CNT_W'(1) : cycles;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int FRAME_W     = 32,
  parameter int CFG_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic [CNT_W-1:0]   conv_cycles,
  input  logic [FRAME_W-2:0] result_i,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [CFG_W-1:0]   cfg_o
);
  localparam int RES_W = FRAME_W - 1;
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic cs_q, sck_q, sdi_q;
  logic cs_prev_q, sck_prev_q;

  adc_sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sck, sdi}),
    .q     ({cs_q, sck_q, sdi_q})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      cs_prev_q  <= cs_q;
      sck_prev_q <= sck_q;
    end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_prev_q & ~cs_q;
  assign cs_rise  = ~cs_prev_q & cs_q;
  assign sck_rise = ~sck_prev_q & sck_q;
  assign sck_fall = sck_prev_q & ~sck_q;

  port_state_e        state_q, state_d;
  logic               sel_q, sel_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [RES_W-1:0]   hold_q, hold_d;
  logic [BIT_W-1:0]   rise_cnt_q, rise_cnt_d;
  logic [BIT_W-1:0]   fall_cnt_q, fall_cnt_d;
  logic [CFG_W-1:0]   cfg_sh_q, cfg_sh_d;
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic               start_q, start_d;
  logic               t_busy, t_done;
  logic               active;

  adc_sp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_q),
    .cycles (conv_cycles),
    .busy   (t_busy),
    .done   (t_done)
  );

  assign active = sel_q & ~cs_q;

  always_comb begin
    state_d    = state_q;
    sel_d      = sel_q;
    shreg_d    = shreg_q;
    hold_d     = hold_q;
    rise_cnt_d = rise_cnt_q;
    fall_cnt_d = fall_cnt_q;
    cfg_sh_d   = cfg_sh_q;
    cfg_d      = cfg_q;
    start_d    = 1'b0;

    if (cs_fall)      sel_d = ~sck_q;
    else if (cs_rise) sel_d = 1'b0;

    unique case (state_q)
      ST_CONV: begin
        if (t_done) begin
          state_d = ST_SLEEP;
          hold_d  = result_i;
          shreg_d = {1'b0, result_i};
        end
      end
      ST_SLEEP: begin
        if (active && sck_rise) begin
          state_d    = ST_XFER;
          rise_cnt_d = BIT_W'(1);
          fall_cnt_d = '0;
          cfg_sh_d   = {{(CFG_W-1){1'b0}}, sdi_q};
        end
      end
      ST_XFER: begin
        if (!active) begin
          state_d    = ST_SLEEP;
          shreg_d    = {1'b0, hold_q};
          rise_cnt_d = '0;
          fall_cnt_d = '0;
        end else begin
          if (sck_rise) begin
            rise_cnt_d = rise_cnt_q + BIT_W'(1);
            if (rise_cnt_q < BIT_W'(CFG_W)) cfg_sh_d = {cfg_sh_q[CFG_W-2:0], sdi_q};
          end
          if (sck_fall) begin
            if (fall_cnt_q == BIT_W'(FRAME_W - 1)) begin
              state_d    = ST_CONV;
              start_d    = ~t_busy;
              cfg_d      = cfg_sh_q;
              rise_cnt_d = '0;
              fall_cnt_d = '0;
            end else begin
              shreg_d    = {shreg_q[FRAME_W-2:0], 1'b0};
              fall_cnt_d = fall_cnt_q + BIT_W'(1);
            end
          end
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CONV;
      sel_q      <= 1'b0;
      shreg_q    <= '0;
      hold_q     <= '0;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
      cfg_sh_q   <= '0;
      cfg_q      <= '0;
      start_q    <= 1'b1;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      shreg_q    <= shreg_d;
      hold_q     <= hold_d;
      rise_cnt_q <= rise_cnt_d;
      fall_cnt_q <= fall_cnt_d;
      cfg_sh_q   <= cfg_sh_d;
      cfg_q      <= cfg_d;
      start_q    <= start_d;
    end
  end

  assign sdo    = (state_q == ST_CONV) ? 1'b1 : shreg_q[FRAME_W-1];
  assign sdo_oe = sel_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk
  import adc_sp_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BIT_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_q,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             t_busy,
  input logic             t_done,
  input logic             start_q,
  input port_state_e      state_q,
  input logic [BIT_W-1:0] rise_cnt,
  input logic [BIT_W-1:0] fall_cnt
);
  p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> !sdo_oe);

  p_eoc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_busy && sdo_oe) |-> sdo);

  p_eoc_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && sdo_oe) |-> !sdo);

  p_sleep_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_done |=> (state_q == ST_SLEEP));

  p_bit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_cnt <= BIT_W'(FRAME_W - 1)) && (rise_cnt <= BIT_W'(FRAME_W)));

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !t_busy);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && cs_q) |=> (state_q == ST_SLEEP));
endmodule

bind adc_serial_port adc_sp_chk #(.FRAME_W(FRAME_W), .BIT_W(BIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_q     (cs_q),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .t_busy   (t_busy),
  .t_done   (t_done),
  .start_q  (start_q),
  .state_q  (state_q),
  .rise_cnt (rise_cnt_q),
  .fall_cnt (fall_cnt_q)
);

// File: tb/adc_serial_port_bench.sv
`timescale 1ns/1ps
module adc_serial_port_bench;
  logic        clk;
  logic        rst_n;
  logic        cs_n, sck, sdi;
  logic [15:0] conv_cycles;
  logic [30:0] result_i;
  logic        sdo, sdo_oe;
  logic [7:0]  cfg_o;

  int n_chk = 0;
  int n_err = 0;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .conv_cycles(conv_cycles), .result_i(result_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_o(cfg_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {result[30:0], cfg[7:0], conversion cycles[15:0]}
  localparam logic [54:0] VECS [4] = '{
    {31'h12345678, 8'hA7, 16'd50},
    {31'h7FFFFFFF, 8'h00, 16'd120},
    {31'h00000000, 8'hFF, 16'd75},
    {31'h55AA33CC, 8'h3C, 16'd200}
  };

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_frame(input logic [31:0] din, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < 32; k++) begin
      sdi = din[31-k];
      clks(4);
      got[31-k] = sdo;
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (sdo !== 1'b0 && cyc < 100000) begin
      clks(1);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int c;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    conv_cycles = 16'd60;
    result_i = VECS[0][54:24];
    clks(5);
    check(sdo_oe == 1'b0, "R11 oe in reset", 32'(sdo_oe), 32'h0);
    check(cfg_o == 8'h00, "R11 cfg in reset", 32'(cfg_o), 32'h0);
    rst_n = 1'b1;
    clks(4);
    cs_n = 1'b0;
    clks(6);
    check(sdo_oe == 1'b1, "R1 enabled with sck low", 32'(sdo_oe), 32'h1);
    check(sdo == 1'b1, "R3 eoc high while converting", 32'(sdo), 32'h1);
    wait_done(c);
    check(c < 100, "R11 first conversion ends", 32'(c), 32'd100);

    for (int i = 0; i < 4; i++) begin
      conv_cycles = VECS[i][15:0];
      read_frame({VECS[i][23:16], 24'hA5C3F0}, got);
      result_i = VECS[(i+1)%4][54:24];
      check(got == {1'b0, VECS[i][54:24]}, "R6 frame", got, {1'b0, VECS[i][54:24]});
      clks(6);
      check(sdo == 1'b1 && sdo_oe == 1'b1, "R7 eoc high after 32nd fall", 32'(sdo), 32'h1);
      check(cfg_o == VECS[i][23:16], "R10 cfg after full transfer", 32'(cfg_o), 32'(VECS[i][23:16]));
      wait_done(c);
      check((c + 6 >= int'(VECS[i][15:0])) && (c + 6 <= int'(VECS[i][15:0]) + 12),
            "R8 conversion length", 32'(c + 6), 32'(VECS[i][15:0]));
    end

    // R9: abort mid-transfer
    for (int k = 0; k < 10; k++) begin
      sdi = 1'b1;
      clks(4);
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
    end
    clks(2);
    cs_n = 1'b1;
    clks(8);
    check(sdo_oe == 1'b0, "R2 hi-z with cs high", 32'(sdo_oe), 32'h0);
    check(cfg_o == 8'h3C, "R10 cfg kept after abort", 32'(cfg_o), 32'h3C);
    cs_n = 1'b0;
    clks(6);
    check(sdo == 1'b0, "R9 sleep after abort", 32'(sdo), 32'h0);
    read_frame({8'h11, 24'h000000}, got);
    check(got == {1'b0, VECS[0][54:24]}, "R9 full frame after abort", got, {1'b0, VECS[0][54:24]});
    result_i = 31'h0ABCDEF1;
    clks(6);
    check(cfg_o == 8'h11, "R10 cfg after reread", 32'(cfg_o), 32'h11);

    // R5: clock edges during conversion ignored
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
      clks(4);
    end
    check(sdo == 1'b1, "R5 still converting", 32'(sdo), 32'h1);
    wait_done(c);
    read_frame(32'h0, got);
    check(got == {1'b0, 31'h0ABCDEF1}, "R5 frame after ignored edges", got, {1'b0, 31'h0ABCDEF1});
    result_i = 31'h2468ACE0;

    // R4: conversion ends while cs high
    clks(6);
    cs_n = 1'b1;
    clks(260);
    cs_n = 1'b0;
    clks(6);
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R4 asleep after cs-high conversion", {sdo_oe, sdo}, 32'h2);
    read_frame(32'h0, got);
    check(got == {1'b0, 31'h2468ACE0}, "R4 captured result", got, {1'b0, 31'h2468ACE0});
    result_i = 31'h13579BDF;
    clks(6);
    cs_n = 1'b1;
    clks(260);

    // R1: sck high at cs fall disables the port
    sck = 1'b1;
    clks(6);
    cs_n = 1'b0;
    clks(8);
    check(sdo_oe == 1'b0, "R1 disabled with sck high", 32'(sdo_oe), 32'h0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b0;
      clks(4);
      sck = 1'b1;
      clks(4);
    end
    check(sdo_oe == 1'b0, "R1 still disabled", 32'(sdo_oe), 32'h0);
    cs_n = 1'b1;
    clks(4);
    sck = 1'b0;
    clks(6);
    cs_n = 1'b0;
    clks(6);
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R1 no transfer happened", {sdo_oe, sdo}, 32'h2);
    conv_cycles = 16'd0;
    read_frame(32'h0, got);
    check(got == {1'b0, 31'h13579BDF}, "R1 full frame", got, {1'b0, 31'h13579BDF});
    clks(1);
    wait_done(c);
    check(c + 1 <= 13, "R8 zero count conversion", 32'(c + 1), 32'd13);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule